// File: doc/BRIEF.md
# Multimode Fixed-Point Multiply-Accumulate Unit

This block multiplies and accumulates unsigned fixed-point operands. A two-bit mode selects how one shared datapath is used. The datapath has four 16x16 partial-product multipliers and one 64-bit adder. In wide mode the unit runs a full 32x32 multiply-accumulate into a 64-bit accumulator. In dual mode it forms two half-width products and adds them to each other, and the accumulator is left alone. In narrow mode it runs a 16x16 multiply-accumulate into a 32-bit accumulator.

The unit has two pipeline stages. The first stage registers the partial products together with the mode that was captured with the valid input. The second stage passes the partial products through the shared adder and updates the accumulator and the result register. The shared adder is a prefix/carry-select hybrid. A synchronous clear resets the accumulator without flushing the pipeline.

Top module: `mmac_top`

## Requirements
- R1: While rst_n is low, out_valid is 0 and res is 0. The accumulator is also 0, so a wide-mode operation with zero operands issued after reset returns 0.
- R2: Mode code 0 (wide) adds the 64-bit product op_a*op_b to the 64-bit accumulator, wrapping modulo 2^64. res shows the new accumulator value.
- R3: Mode code 1 (dual) outputs res = {32'b0, (op_a[15:0]*op_b[15:0] + op_a[31:16]*op_b[31:16]) mod 2^32}. The accumulator is not changed.
- R4: Mode code 2 (narrow) sets the accumulator to {32'b0, (acc[31:0] + op_a[15:0]*op_b[15:0]) mod 2^32}. res shows this value, and its upper 32 bits are zero.
- R5: An accepted input raises out_valid for exactly one cycle, two cycles after the cycle in which in_valid was high. Inputs issued on consecutive cycles each produce a result, in order, and each result includes the accumulation from the one before it.
- R6: When clr is high on a cycle, the accumulator is zeroed at the next edge. Any result completing at that edge is dropped (out_valid stays 0). An operation that is entering the pipeline on that same cycle still completes, starting from zero.
- R7: When in_valid is low, the mode and operand inputs have no effect. No result is produced and the accumulator is unchanged.
- R8: Mode code 3 is reserved. A valid input carrying it produces no result and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 0 wide MAC, 1 dual product sum, 2 narrow MAC, 3 reserved |
| clr | input | 1 | Synchronous accumulator clear |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | res holds a new result this cycle |
| res | output | 64 | Result or accumulator value |

## Verification
The latency and reserved-code properties assume that in_valid, mode and clr are steady around the sampling edge. They also assume that clr is never expected to cancel an operation that is still in the first stage. The bench drives every input at the falling clock edge, and it raises clr only on the cycles the clear tests call for. The adder property checks the prefix/carry-select sum against plain addition for every operand pair that reaches the adder. The wrap vectors drive carries across every block boundary so that this check exercises the whole carry tree.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
  typedef enum logic [1:0] {
    MD_WIDE   = 2'd0,
    MD_DUAL   = 2'd1,
    MD_NARROW = 2'd2,
    MD_RSVD   = 2'd3
  } mmac_mode_e;
endpackage

// File: rtl/mmac_vmul.sv
// Crosswise decomposition: an operand split into halves gives four
// half-width products, which the top combines per mode.
module mmac_vmul #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] a,
  input  logic [2*HW-1:0] b,
  output logic [2*HW-1:0] pp [4]
);
  logic [HW-1:0] a_h [2];
  logic [HW-1:0] b_h [2];

  assign a_h[0] = a[HW-1:0];
  assign a_h[1] = a[2*HW-1:HW];
  assign b_h[0] = b[HW-1:0];
  assign b_h[1] = b[2*HW-1:HW];

  // pp index = {a half, b half}: 0 = lo*lo, 1 = lo*hi, 2 = hi*lo, 3 = hi*hi
  for (genvar i = 0; i < 4; i++) begin : g_cross
    assign pp[i] = (2*HW)'(a_h[i/2]) * (2*HW)'(b_h[i%2]);
  end
endmodule

// File: rtl/mmac_hadd.sv
// Carry-select blocks with block carries from a Brent-Kung prefix tree.
module mmac_hadd #(
  parameter int W   = 64,
  parameter int BLK = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int NB = W / BLK;

  logic [NB-1:0]  g_blk;
  logic [NB-1:0]  p_blk;
  logic [NB:0]    c_in;
  logic [BLK-1:0] s0 [NB];
  logic [BLK-1:0] s1 [NB];

  for (genvar k = 0; k < NB; k++) begin : g_blk_sel
    logic [BLK-1:0] xb, yb;
    assign xb = x[k*BLK +: BLK];
    assign yb = y[k*BLK +: BLK];
    assign {g_blk[k], s0[k]} = {1'b0, xb} + {1'b0, yb};
    assign s1[k]             = xb + yb + {{(BLK-1){1'b0}}, 1'b1};
    assign p_blk[k]          = &(xb ^ yb);
    assign s[k*BLK +: BLK]   = c_in[k] ? s1[k] : s0[k];
  end

  always_comb begin
    logic [NB-1:0] gg, pg;
    gg = g_blk;
    pg = p_blk;
    for (int d = 1; d < NB; d = d * 2) begin
      for (int i = 2*d - 1; i < NB; i = i + 2*d) begin
        gg[i] = gg[i] | (pg[i] & gg[i-d]);
        pg[i] = pg[i] & pg[i-d];
      end
    end
    for (int d = NB / 4; d >= 1; d = d / 2) begin
      for (int i = 3*d - 1; i < NB; i = i + 2*d) begin
        gg[i] = gg[i] | (pg[i] & gg[i-d]);
        pg[i] = pg[i] & pg[i-d];
      end
    end
    c_in = {gg, 1'b0};
  end

  always_comb begin
    a_r2_hadd_sum: assert (s == W'(x + y))
      else $error("hybrid adder sum mismatch");
  end
endmodule

// File: rtl/mmac_top.sv
module mmac_top
  import mmac_pkg::*;
#(
  parameter int OPW = 32,
  parameter int BLK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             clr,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  output logic             out_valid,
  output logic [2*OPW-1:0] res
);
  localparam int HW   = OPW / 2;
  localparam int ACCW = 2 * OPW;

  mmac_mode_e      mode_in;
  logic [OPW-1:0]  pp_d [4];
  logic [OPW-1:0]  pp_q [4];
  mmac_mode_e      mode_q;
  logic            v1_q;
  logic            v1_d;

  logic [ACCW-1:0] acc_q, acc_d;
  logic [ACCW-1:0] res_d;
  logic            ov_d;
  logic            acc_en, res_en;
  logic [ACCW-1:0] add_x, add_y, add_s;
  logic [ACCW-1:0] prod_w;

  assign mode_in = mmac_mode_e'(mode);

  mmac_vmul #(.HW(HW)) u_vmul (
    .a  (op_a),
    .b  (op_b),
    .pp (pp_d)
  );

  // Stage 1: partial products and the mode captured with the valid input
  assign v1_d = in_valid && (mode_in != MD_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      mode_q <= MD_WIDE;
      for (int i = 0; i < 4; i++) pp_q[i] <= '0;
    end else begin
      v1_q <= v1_d;
      if (in_valid) begin
        mode_q <= mode_in;
        for (int i = 0; i < 4; i++) pp_q[i] <= pp_d[i];
      end
    end
  end

  // Stage 2: shared adder, operand steering per mode
  assign prod_w = ACCW'(pp_q[0])
                + (ACCW'(pp_q[1]) << HW)
                + (ACCW'(pp_q[2]) << HW)
                + (ACCW'(pp_q[3]) << OPW);

  always_comb begin
    unique case (mode_q)
      MD_DUAL: begin
        add_x = ACCW'(pp_q[0]);
        add_y = ACCW'(pp_q[3]);
      end
      MD_NARROW: begin
        add_x = ACCW'(acc_q[OPW-1:0]);
        add_y = ACCW'(pp_q[0]);
      end
      default: begin
        add_x = acc_q;
        add_y = prod_w;
      end
    endcase
  end

  mmac_hadd #(.W(ACCW), .BLK(BLK)) u_hadd (
    .x (add_x),
    .y (add_y),
    .s (add_s)
  );

  always_comb begin
    ov_d   = v1_q && !clr;
    res_en = ov_d;
    acc_en = clr || (v1_q && (mode_q != MD_DUAL));
    if (mode_q == MD_WIDE) res_d = add_s;
    else                   res_d = ACCW'(add_s[OPW-1:0]);
    if (clr) acc_d = '0;
    else     acc_d = res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ov_d;
      if (acc_en) acc_q <= acc_d;
      if (res_en) res   <= res_d;
    end
  end

  // Properties
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd3) ##1 !clr |=> out_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  a_r6_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);
  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> ##1 !out_valid);
  a_r3_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && mode_q == MD_DUAL && !clr) |=> $stable(acc_q));
  a_r4_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && mode_q == MD_NARROW && !clr) |=> (res[ACCW-1:OPW] == '0));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(clr)) |-> $stable(acc_q));
endmodule

// File: tb/mmac_top_tb.sv
module mmac_top_tb;
  typedef struct packed {
    logic [1:0]  md;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_0003, 32'h0000_0004},
    '{2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd1, 32'h0002_0003, 32'h0005_0007},
    '{2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd0, 32'h8000_0001, 32'h7FFF_FFFF},
    '{2'd2, 32'h0000_1234, 32'h0000_0010},
    '{2'd2, 32'hABCD_FFFF, 32'h1234_FFFF},
    '{2'd2, 32'h0000_FFFF, 32'h0000_FFFF},
    '{2'd0, 32'h1234_5678, 32'h9ABC_DEF0},
    '{2'd1, 32'h1234_5678, 32'h9ABC_DEF0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic        clr;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [63:0] res;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [63:0] acc_m;

  always #4 clk = ~clk;

  mmac_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .clr       (clr),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .res       (res)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Reference model from the requirements; returns the expected res
  function automatic logic [63:0] model(input logic [1:0] md, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] lo, hi, n;
    lo = a[15:0] * b[15:0];
    hi = a[31:16] * b[31:16];
    case (md)
      2'd0: begin
        acc_m = acc_m + ({32'b0, a} * {32'b0, b});
        return acc_m;
      end
      2'd1: begin
        n = lo + hi;
        return {32'b0, n};
      end
      default: begin
        n = acc_m[31:0] + lo;
        acc_m = {32'b0, n};
        return acc_m;
      end
    endcase
  endfunction

  task automatic op(input logic [1:0] md, input logic [31:0] a, input logic [31:0] b,
                    input string req);
    logic [63:0] e;
    e = model(md, a, b);
    @(negedge clk);
    in_valid = 1'b1; mode = md; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
    chk({req, " res"}, res, e);
  endtask

  // Brings out the accumulator through a wide-mode 0*0 operation
  task automatic readout(input string req);
    op(2'd0, 32'd0, 32'd0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e2, e3;
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'd0; clr = 1'b0; op_a = '0; op_b = '0;
    acc_m = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R1 reset res", res, 64'd0);
    rst_n = 1'b1;
    readout("R1 reset accumulator");

    // Table walk: R2 wide, R3 dual, R4 narrow
    for (int i = 0; i < NV; i++) begin
      op(VECS[i].md, VECS[i].a, VECS[i].b,
         VECS[i].md == 2'd0 ? "R2 wide" : (VECS[i].md == 2'd1 ? "R3 dual" : "R4 narrow"));
    end
    readout("R3 dual leaves accumulator");

    // R6 clear drops a completing result
    @(negedge clk);
    in_valid = 1'b1; mode = 2'd0; op_a = 32'd3; op_b = 32'd5;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R6 clear drops result", {63'b0, out_valid}, 64'd0);
    acc_m = '0;
    readout("R6 clear zeroes accumulator");

    // R6 clear alongside an entering operation
    @(negedge clk);
    in_valid = 1'b1; mode = 2'd0; op_a = 32'd7; op_b = 32'd9; clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    @(negedge clk);
    chk("R6 entering op valid", {63'b0, out_valid}, 64'd1);
    chk("R6 entering op res", res, 64'd63);
    acc_m = 64'd63;

    // R2 carry through every block and wrap
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; acc_m = '0;
    op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 wide max product");
    op(2'd0, 32'hFFFF_FFFF, 32'd2, "R2 wide all ones");
    op(2'd0, 32'd1, 32'd1, "R2 wide wrap to zero");

    // R5 back-to-back issue
    e1 = model(2'd0, 32'h0001_0001, 32'h0000_0100);
    e2 = model(2'd0, 32'hDEAD_BEEF, 32'h0000_0003);
    e3 = model(2'd2, 32'h0000_8000, 32'h0000_0004);
    @(negedge clk);
    in_valid = 1'b1; mode = 2'd0; op_a = 32'h0001_0001; op_b = 32'h0000_0100;
    @(negedge clk);
    op_a = 32'hDEAD_BEEF; op_b = 32'h0000_0003;
    @(negedge clk);
    mode = 2'd2; op_a = 32'h0000_8000; op_b = 32'h0000_0004;
    chk("R5 stream first valid", {63'b0, out_valid}, 64'd1);
    chk("R5 stream first res", res, e1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 stream second res", res, e2);
    @(negedge clk);
    chk("R5 stream third res", res, e3);
    @(negedge clk);
    chk("R5 single cycle pulse", {63'b0, out_valid}, 64'd0);

    // R7 inputs ignored while in_valid is low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mode = 2'(i); op_a = 32'h1111_1111 * (i + 1); op_b = 32'hFFFF_0000 >> i;
      chk("R7 idle no result", {63'b0, out_valid}, 64'd0);
    end
    readout("R7 idle accumulator unchanged");

    // R8 reserved mode code
    @(negedge clk);
    in_valid = 1'b1; mode = 2'd3; op_a = 32'h0000_FFFF; op_b = 32'h0000_FFFF;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 reserved no result", {63'b0, out_valid}, 64'd0);
    readout("R8 reserved accumulator unchanged");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule